// File: doc/BRIEF.md
# Reloading Software Interrupt Timer

This block is a free-running interval timer that the host programs. A fixed prescaler divides the time base clock by 256. Under the prescaler sits a 16-bit unsigned unit counter. When the unit counter runs out, the block raises a sticky status flag, loads the programmed interval again and keeps counting without a pause. The interrupt line follows the flag only while the host has enabled it. The counting itself never depends on the enable.

The host reaches the block through a single-cycle write port that has two word addresses. Address 0 holds the interval in prescaler units. Writing it restarts the count at once from the new value. Address 1 is the control word. Bit 0 of that word is the interrupt enable. Writing a 1 to bit 1 clears the flag. With a 20 MHz time base, the reset interval of FFFFh gives roughly 838 ms between interrupts. The prescaler width and the reset interval are parameters, so a shorter variant can be instantiated.

Top module: `swint_timer`

## Requirements
- R1: While reset is held and right after it is released, `tmr_flag` and `tmr_irq` are 0 and the interrupt enable is 0.
- R2: The timer counts whether or not the interrupt is enabled. With the enable at 0, the flag still sets on expiry while `tmr_irq` stays 0.
- R3: After an expiry, the timer reloads from the stored interval and expires again exactly interval × 2^PRESCALE_W clock edges later, with no cycles lost. The default PRESCALE_W of 8 gives 256 clocks per unit.
- R4: After reset, the stored interval equals the parameter RELOAD_INIT (default FFFFh). The first expiry comes RELOAD_INIT × 2^PRESCALE_W edges after reset is released.
- R5: A write to address 0 (`cfg_addr`=0) stores `cfg_wdata` as the interval and restarts both the prescaler and the unit counter at that edge. The next expiry comes value × 2^PRESCALE_W edges after the write edge, even if a count was already in progress.
- R6: An interval value of 0 behaves as 1: the timer expires every 2^PRESCALE_W edges.
- R7: A write to address 1 sets the interrupt enable to bit 0 of `cfg_wdata`. `tmr_irq` equals `tmr_flag` AND the enable.
- R8: In a write to address 1, bit 1 = 1 clears `tmr_flag` at that edge. Bit 1 = 0 leaves the flag unchanged.
- R9: If an expiry and a flag clear fall on the same edge, the flag ends up set.
- R10: A write to address 1 does not restart or shift the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe, one cycle per write |
| cfg_addr | input | 1 | 0 = interval register, 1 = control word |
| cfg_wdata | input | RELOAD_W | Write data |
| tmr_flag | output | 1 | Sticky expiry status |
| tmr_irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
The hardest case to reach is a flag clear that lands on the exact edge where the timer expires (R9). A second hard case is an interval rewrite partway through a count (R5). The bench makes both happen on purpose. It first writes an interval of 0, which places the phase at a known edge and makes the period short. It then times the clear write so that its edge is the eighth edge after the rewrite. A behavioural countdown model runs alongside and predicts the flag and the interrupt on every cycle. Every divergence is reported.

// File: rtl/swt_pkg.sv
package swt_pkg;

   typedef enum logic {
      SWT_REG_INTERVAL = 1'b0,
      SWT_REG_CONTROL  = 1'b1
   } swt_reg_e;

   localparam int SWT_CTL_IEN = 0;
   localparam int SWT_CTL_CLR = 1;

endpackage

// File: rtl/swt_prescaler.sv
module swt_prescaler #(
   parameter int PRESCALE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   generate
      if (PRESCALE_W == 0) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_div
         localparam logic [PRESCALE_W-1:0] TOP = '1;
         logic [PRESCALE_W-1:0] div_q;

         always_ff @(posedge clk) begin
            if (!rst_n || restart || div_q == '0) begin
               div_q <= TOP;
            end else begin
               div_q <= div_q - 1'b1;
            end
         end

         assign tick = (div_q == '0);
      end
   endgenerate

endmodule

// File: rtl/swt_unit_counter.sv
module swt_unit_counter #(
   parameter int                RELOAD_W  = 16,
   parameter logic [RELOAD_W-1:0] START_RST = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                restart,
   input  logic [RELOAD_W-1:0] start_val,
   output logic                expire
);

   logic [RELOAD_W-1:0] unit_q;

   assign expire = tick && (unit_q == RELOAD_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unit_q <= START_RST;
      end else if (restart || expire) begin
         unit_q <= start_val;
      end else if (tick) begin
         unit_q <= unit_q - 1'b1;
      end
   end

endmodule

// File: rtl/swt_status.sv
module swt_status (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clr_req,
   input  logic ien_we,
   input  logic ien_val,
   output logic flag,
   output logic irq,
   output logic ien
);

   logic flag_q;
   logic ien_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (expire) begin
         flag_q <= 1'b1;
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q <= 1'b0;
      end else if (ien_we) begin
         ien_q <= ien_val;
      end
   end

   assign flag = flag_q;
   assign ien  = ien_q;
   assign irq  = flag_q & ien_q;

endmodule

// File: rtl/swint_timer.sv
module swint_timer #(
   parameter int                  PRESCALE_W  = 8,
   parameter int                  RELOAD_W    = 16,
   parameter logic [RELOAD_W-1:0] RELOAD_INIT = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_addr,
   input  logic [RELOAD_W-1:0] cfg_wdata,
   output logic                tmr_flag,
   output logic                tmr_irq
);

   import swt_pkg::*;

   localparam logic [RELOAD_W-1:0] ONE_UNIT  = RELOAD_W'(1);
   localparam logic [RELOAD_W-1:0] INIT_EFF  = (RELOAD_INIT == '0) ? ONE_UNIT : RELOAD_INIT;

   if (RELOAD_W < 2) begin : g_bad_width
      $error("swint_timer: RELOAD_W must be at least 2");
   end
   if (PRESCALE_W < 0 || PRESCALE_W > 24) begin : g_bad_prescale
      $error("swint_timer: PRESCALE_W out of range");
   end

   function automatic logic [RELOAD_W-1:0] clamp_unit(input logic [RELOAD_W-1:0] v);
      return (v == '0) ? ONE_UNIT : v;
   endfunction

   logic                wr_interval;
   logic                wr_control;
   logic                clr_req;
   logic [RELOAD_W-1:0] interval_q;
   logic [RELOAD_W-1:0] start_val;
   logic                pre_tick;
   logic                tmr_expire;
   logic                ien_q;

   assign wr_interval = cfg_we && (swt_reg_e'(cfg_addr) == SWT_REG_INTERVAL);
   assign wr_control  = cfg_we && (swt_reg_e'(cfg_addr) == SWT_REG_CONTROL);
   assign clr_req     = wr_control && cfg_wdata[SWT_CTL_CLR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         interval_q <= RELOAD_INIT;
      end else if (wr_interval) begin
         interval_q <= cfg_wdata;
      end
   end

   assign start_val = wr_interval ? clamp_unit(cfg_wdata) : clamp_unit(interval_q);

   swt_prescaler #(
      .PRESCALE_W (PRESCALE_W)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_interval),
      .tick    (pre_tick)
   );

   swt_unit_counter #(
      .RELOAD_W  (RELOAD_W),
      .START_RST (INIT_EFF)
   ) u_units (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (pre_tick),
      .restart   (wr_interval),
      .start_val (start_val),
      .expire    (tmr_expire)
   );

   swt_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (tmr_expire),
      .clr_req (clr_req),
      .ien_we  (wr_control),
      .ien_val (cfg_wdata[SWT_CTL_IEN]),
      .flag    (tmr_flag),
      .irq     (tmr_irq),
      .ien     (ien_q)
   );

endmodule

// File: rtl/swint_timer_chk.sv
module swint_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_interval,
   input logic wr_big,
   input logic clr_req,
   input logic ien_off,
   input logic expire,
   input logic flag,
   input logic irq
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!flag && !irq));

   // R3
   expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);

   // R9
   expire_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && clr_req) |=> flag);

   // R8
   clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !expire) |=> !flag);

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!expire && !clr_req) |=> $stable(flag));

   // R7
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   // R7
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ien_off |=> !irq);

   // R5
   restart_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_interval && wr_big) |=> !expire);

endmodule

bind swint_timer swint_timer_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_interval (wr_interval),
   .wr_big      (cfg_wdata > RELOAD_W'(1)),
   .clr_req     (clr_req),
   .ien_off     (wr_control && !cfg_wdata[0]),
   .expire      (tmr_expire),
   .flag        (tmr_flag),
   .irq         (tmr_irq)
);

// File: tb/swint_timer_test.sv
module swint_timer_test;

   localparam int PW    = 3;
   localparam int SCALE = 1 << PW;
   localparam int RW    = 16;
   localparam int INIT  = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_addr = 1'b0;
   logic [RW-1:0] cfg_wdata = '0;
   logic          tmr_flag;
   logic          tmr_irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string phase = "R1";

   int m_rem;
   int m_reload;
   bit m_flag;
   bit m_ien;

   always #2 clk = ~clk;

   swint_timer #(
      .PRESCALE_W  (PW),
      .RELOAD_W    (RW),
      .RELOAD_INIT (RW'(INIT))
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .tmr_flag  (tmr_flag),
      .tmr_irq   (tmr_irq)
   );

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   // behavioural reference: remaining edges until the next expiry
   always @(posedge clk) begin
      bit exp_now;
      if (!rst_n) begin
         m_rem    = INIT * SCALE;
         m_reload = INIT;
         m_flag   = 1'b0;
         m_ien    = 1'b0;
      end else begin
         exp_now = (m_rem == 1);
         if (cfg_we && !cfg_addr) begin
            m_reload = int'(cfg_wdata);
            m_rem    = eff(m_reload) * SCALE;
         end else if (exp_now) begin
            m_rem = eff(m_reload) * SCALE;
         end else begin
            m_rem = m_rem - 1;
         end
         if (cfg_we && cfg_addr) m_ien = cfg_wdata[0];
         if (exp_now) m_flag = 1'b1;
         else if (cfg_we && cfg_addr && cfg_wdata[1]) m_flag = 1'b0;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (tmr_flag !== m_flag || tmr_irq !== (m_flag && m_ien)) begin
            errors++;
            $display("FAIL %s model: flag=%b irq=%b expected flag=%b irq=%b",
                     phase, tmr_flag, tmr_irq, m_flag, m_flag && m_ien);
         end
      end
   end

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic addr, input int data);
      cfg_we    = 1'b1;
      cfg_addr  = addr;
      cfg_wdata = RW'(data);
      @(negedge clk);
      cfg_we    = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      step(4);
      check("R1", tmr_flag, 1'b0, "flag in reset");
      check("R1", tmr_irq, 1'b0, "irq in reset");
      rst_n = 1'b1;
      step(1);
      check("R1", tmr_flag, 1'b0, "flag after reset");

      // R4 / R2: first expiry at INIT*SCALE with irq disabled
      phase = "R4";
      step(INIT * SCALE - 2);
      check("R4", tmr_flag, 1'b0, "flag one edge before first expiry");
      step(1);
      check("R4", tmr_flag, 1'b1, "flag at first expiry");
      check("R2", tmr_irq, 1'b0, "irq with enable off");

      // R7 enable gating
      phase = "R7";
      wr(1'b1, 1);
      check("R7", tmr_irq, 1'b1, "irq after enable");
      wr(1'b1, 0);
      check("R7", tmr_irq, 1'b0, "irq after disable");
      check("R7", tmr_flag, 1'b1, "flag kept when disabling");

      // R8 clear semantics
      phase = "R8";
      wr(1'b1, 1);
      check("R8", tmr_flag, 1'b1, "bit1=0 leaves flag");
      wr(1'b1, 3);
      check("R8", tmr_flag, 1'b0, "bit1=1 clears flag");
      check("R8", tmr_irq, 1'b0, "irq after clear");

      // R5 interval write restarts
      phase = "R5";
      wr(1'b0, 5);
      step(39);
      check("R5", tmr_flag, 1'b0, "before new period ends");
      step(1);
      check("R5", tmr_flag, 1'b1, "at new period end");
      check("R7", tmr_irq, 1'b1, "irq follows flag when enabled");

      // R3 automatic reload
      phase = "R3";
      wr(1'b1, 3);
      step(38);
      check("R3", tmr_flag, 1'b0, "before reloaded period ends");
      step(1);
      check("R3", tmr_flag, 1'b1, "second expiry after reload");

      // R9 clear colliding with expiry, R6 zero interval
      phase = "R9";
      wr(1'b1, 3);
      wr(1'b0, 0);
      step(7);
      check("R6", tmr_flag, 1'b0, "zero interval before 8 edges");
      wr(1'b1, 3);
      check("R9", tmr_flag, 1'b1, "expiry wins over clear");
      phase = "R6";
      wr(1'b1, 3);
      check("R6", tmr_flag, 1'b0, "cleared after collision");
      step(6);
      check("R6", tmr_flag, 1'b0, "zero interval mid period");
      step(1);
      check("R6", tmr_flag, 1'b1, "zero interval expires every 8");

      // R10 control write does not restart
      phase = "R10";
      wr(1'b1, 3);
      wr(1'b0, 4);
      step(9);
      wr(1'b1, 0);
      step(21);
      check("R10", tmr_flag, 1'b0, "before unshifted expiry");
      step(1);
      check("R10", tmr_flag, 1'b1, "expiry not shifted by control write");
      check("R2", tmr_irq, 1'b0, "irq off while counting disabled");

      // R5 rewrite mid-count
      phase = "R5";
      wr(1'b1, 2);
      wr(1'b0, 3);
      step(20);
      wr(1'b0, 2);
      step(15);
      check("R5", tmr_flag, 1'b0, "old period abandoned");
      step(1);
      check("R5", tmr_flag, 1'b1, "rewritten period expiry");

      step(4);
      finish_run();
   end

endmodule